// File: doc/BRIEF.md
# Character Glyph Row Fetch Unit

This block supplies the dot pattern for one horizontal slice of a character cell. A display scan engine presents an 8-bit character code, a 4-bit row index and a font-height select, and one clock later receives a 5-bit pattern, qualified by a valid strobe. In the pattern, a 1 marks a dot that is driven dark.

Codes 0x00 to 0x0F come from a 64-byte glyph RAM that the host loads through a simple write port. It holds eight short (5x8) glyphs or four tall (5x10) glyphs. Every other code comes from a fixed glyph table that is addressed by the code joined to the row. The unit here carries a computed stand-in table in place of a production font. Rows beyond the height of the selected font always come out blank. A code the table does not program shows every dot lit, as an erased table would.

Top module: `glyph_row_fetch`

## Requirements
- R1: For a code c at or above 0x10 and below the programmed limit (default 0x80), with a row r inside the font height, the table byte is {3'b111, c[4:0] ^ {1'b0, r}}.
- R2: Only the five low bits of any fetched byte reach pat_bits. The three upper bits are dropped.
- R3: With req_tall=0 (short font), any row index of 8 or more yields pat_bits = 0, whatever the code.
- R4: With req_tall=1 (tall font), any row index of 10 or more yields pat_bits = 0, whatever the code.
- R5: With req_tall=0, codes 0x00 to 0x0F read glyph RAM byte {code[2:0], row[2:0]}, so code 0x08 aliases code 0x00.
- R6: With req_tall=1, codes 0x00 to 0x0F read glyph RAM byte {code[1:0], row[3:0]}, so code 0x04 aliases code 0x00.
- R7: A code at or above the programmed limit, with a row inside the font height, yields pat_bits = 5'b11111.
- R8: pat_valid is high exactly in the cycle after a cycle with req_valid high. pat_bits belongs to that request.
- R9: A glyph RAM write in the same cycle as a fetch of the same RAM byte takes effect first, so the fetch returns the new byte.
- R10: After reset, pat_valid and pat_bits are 0 and every glyph RAM byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request strobe |
| req_code | input | 8 | Character code |
| req_row | input | 4 | Row within the character cell |
| req_tall | input | 1 | 0: 5x8 font, 1: 5x10 font |
| wr_en | input | 1 | Glyph RAM write enable |
| wr_addr | input | 6 | Glyph RAM byte address |
| wr_data | input | 8 | Glyph RAM write byte |
| pat_valid | output | 1 | Pattern valid, one cycle after request |
| pat_bits | output | 5 | Row pattern, 1 = lit dot |

## Verification
The bench probes the seams between the two address layouts. Code 0x08 in short mode and code 0x04 in tall mode must alias RAM slot zero. A design that keeps too many code bits would read an unwritten byte instead. Rows 8 and 9 are lit in tall mode but blank in short mode, so a swapped or off-by-one height limit changes the pattern right at the boundary. Separate checks cover a fetch that meets a same-cycle write, where a design that reads before writing returns the stale byte. They also cover an unprogrammed code, where a wrong default returns zeros, and the upper table bits, which leak into the pattern if the masking is wrong.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

   typedef enum logic {
      FONT_SHORT = 1'b0,
      FONT_TALL  = 1'b1
   } font_e;

   typedef struct packed {
      logic use_ram;
      logic blank;
   } fetch_sel_t;

endpackage

// File: rtl/glyph_addr_gen.sv
module glyph_addr_gen
   import glyph_pkg::*;
#(
   parameter int CODE_W     = 8,
   parameter int ROW_W      = 4,
   parameter int RAM_AW     = 6,
   parameter int RAM_CODES  = 16,
   parameter int SHORT_ROWS = 8,
   parameter int TALL_ROWS  = 10
) (
   input  logic [CODE_W-1:0] code,
   input  logic [ROW_W-1:0]  row,
   input  font_e             font,
   output fetch_sel_t        sel,
   output logic [RAM_AW-1:0] ram_addr
);
   localparam int SHORT_RB = $clog2(SHORT_ROWS);
   localparam int TALL_RB  = $clog2(TALL_ROWS);
   localparam int SHORT_CB = RAM_AW - SHORT_RB;
   localparam int TALL_CB  = RAM_AW - TALL_RB;
   localparam logic [ROW_W-1:0]  SHORT_LIM = ROW_W'(SHORT_ROWS);
   localparam logic [ROW_W-1:0]  TALL_LIM  = ROW_W'(TALL_ROWS);
   localparam logic [CODE_W-1:0] RAM_LIM   = CODE_W'(RAM_CODES);

   if (TALL_RB > ROW_W) begin : g_bad_row_w
      $error("glyph_addr_gen: ROW_W too narrow for TALL_ROWS");
   end
   if (SHORT_CB < 1 || TALL_CB < 1) begin : g_bad_ram_aw
      $error("glyph_addr_gen: RAM_AW leaves no code bits");
   end

   logic             past_height;
   logic [ROW_W-1:0] row_eff;

   always_comb begin
      past_height = (font == FONT_TALL) ? (row >= TALL_LIM) : (row >= SHORT_LIM);
      row_eff     = past_height ? '0 : row;
      sel.blank   = past_height;
      sel.use_ram = (code < RAM_LIM);
      if (font == FONT_TALL)
         ram_addr = {code[TALL_CB-1:0], row_eff[TALL_RB-1:0]};
      else
         ram_addr = {code[SHORT_CB-1:0], row_eff[SHORT_RB-1:0]};
   end

endmodule

// File: rtl/glyph_ram.sv
module glyph_ram #(
   parameter int AW = 6,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   // same-cycle write wins over the stored byte
   always_comb begin
      if (wr_en && (wr_addr == rd_addr)) rd_data = wr_data;
      else                               rd_data = mem[rd_addr];
   end

endmodule

// File: rtl/glyph_rom.sv
module glyph_rom #(
   parameter int CODE_W       = 8,
   parameter int ROW_W        = 4,
   parameter int DW           = 8,
   parameter int RAM_CODES    = 16,
   parameter int PROG_LIMIT   = 128,
   parameter bit ERASED_TABLE = 1'b0
) (
   input  logic [CODE_W-1:0] code,
   input  logic [ROW_W-1:0]  row,
   output logic [DW-1:0]     data
);
   localparam int PIX_W = 5;
   localparam logic [CODE_W:0] RES_LIM  = (CODE_W+1)'(RAM_CODES);
   localparam logic [CODE_W:0] PROG_LIM = (CODE_W+1)'(PROG_LIMIT);

   if (DW < PIX_W + 3) begin : g_bad_dw
      $error("glyph_rom: DW must hold pattern and spare bits");
   end
   if (ROW_W >= PIX_W) begin : g_bad_row
      $error("glyph_rom: ROW_W must be narrower than the pattern");
   end

   logic [CODE_W:0] code_x;
   assign code_x = {1'b0, code};

   if (ERASED_TABLE) begin : g_erased
      logic unused_row;
      assign unused_row = ^row;
      always_comb begin
         if (code_x < RES_LIM) data = '0;
         else                  data = '1;
      end
   end else begin : g_stand_in
      logic [PIX_W-1:0] mix;
      always_comb begin
         mix = code[PIX_W-1:0] ^ PIX_W'(row);
         if (code_x < RES_LIM)        data = '0;
         else if (code_x >= PROG_LIM) data = '1;
         else                         data = {{(DW-PIX_W){1'b1}}, mix};
      end
   end

endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch
   import glyph_pkg::*;
#(
   parameter int CODE_W     = 8,
   parameter int ROW_W      = 4,
   parameter int PIX_W      = 5,
   parameter int DATA_W     = 8,
   parameter int RAM_AW     = 6,
   parameter int RAM_CODES  = 16,
   parameter int SHORT_ROWS = 8,
   parameter int TALL_ROWS  = 10,
   parameter int PROG_LIMIT = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CODE_W-1:0] req_code,
   input  logic [ROW_W-1:0]  req_row,
   input  logic              req_tall,
   input  logic              wr_en,
   input  logic [RAM_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pat_valid,
   output logic [PIX_W-1:0]  pat_bits
);
   if (PIX_W > DATA_W) begin : g_bad_pix
      $error("glyph_row_fetch: PIX_W exceeds DATA_W");
   end
   if ((1 << RAM_AW) != RAM_CODES * 4) begin : g_bad_ram
      $error("glyph_row_fetch: RAM size does not match reserved codes");
   end

   font_e             font;
   fetch_sel_t        sel;
   logic [RAM_AW-1:0] ram_addr;
   logic [DATA_W-1:0] ram_data;
   logic [DATA_W-1:0] rom_data;
   logic [DATA_W-1:0] fetched;
   logic [PIX_W-1:0]  pix_next;

   assign font = req_tall ? FONT_TALL : FONT_SHORT;

   glyph_addr_gen #(
      .CODE_W(CODE_W), .ROW_W(ROW_W), .RAM_AW(RAM_AW), .RAM_CODES(RAM_CODES),
      .SHORT_ROWS(SHORT_ROWS), .TALL_ROWS(TALL_ROWS)
   ) addr_i (
      .code(req_code), .row(req_row), .font(font), .sel(sel), .ram_addr(ram_addr)
   );

   glyph_ram #(.AW(RAM_AW), .DW(DATA_W)) ram_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(ram_addr), .rd_data(ram_data)
   );

   glyph_rom #(
      .CODE_W(CODE_W), .ROW_W(ROW_W), .DW(DATA_W), .RAM_CODES(RAM_CODES),
      .PROG_LIMIT(PROG_LIMIT), .ERASED_TABLE(1'b0)
   ) rom_i (
      .code(req_code), .row(req_row), .data(rom_data)
   );

   always_comb begin
      fetched  = sel.use_ram ? ram_data : rom_data;
      pix_next = sel.blank ? '0 : fetched[PIX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pat_valid <= 1'b0;
         pat_bits  <= '0;
      end else begin
         pat_valid <= req_valid;
         if (req_valid) pat_bits <= pix_next;
      end
   end

   localparam logic [CODE_W:0] PROG_LIM_X = (CODE_W+1)'(PROG_LIMIT);
   localparam logic [ROW_W-1:0] SHORT_LIM = ROW_W'(SHORT_ROWS);
   localparam logic [ROW_W-1:0] TALL_LIM  = ROW_W'(TALL_ROWS);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> pat_valid); // R8
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !pat_valid); // R8
   AST_SHORT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_tall && req_row >= SHORT_LIM) |=> (pat_bits == '0)); // R3
   AST_TALL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_tall && req_row >= TALL_LIM) |=> (pat_bits == '0)); // R4
   AST_UNPROG_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && {1'b0, req_code} >= PROG_LIM_X &&
       req_row < (req_tall ? TALL_LIM : SHORT_LIM)) |=> (pat_bits == '1)); // R7

endmodule

// File: tb/glyph_row_fetch_tb_top.sv
module glyph_row_fetch_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       req_valid;
   logic [7:0] req_code;
   logic [3:0] req_row;
   logic       req_tall;
   logic       wr_en;
   logic [5:0] wr_addr;
   logic [7:0] wr_data;
   logic       pat_valid;
   logic [4:0] pat_bits;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   glyph_row_fetch dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
      .req_row(req_row), .req_tall(req_tall), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pat_valid(pat_valid), .pat_bits(pat_bits)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // expected pattern for a table code (R1, R2, R7)
   function automatic logic [4:0] table_pat(input logic [7:0] c, input logic [3:0] r);
      if (c >= 8'h80) return 5'h1F;
      return c[4:0] ^ {1'b0, r};
   endfunction

   task automatic write_ram(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic fetch(input logic [7:0] c, input logic [3:0] r, input logic t,
                        output logic [4:0] got);
      @(negedge clk);
      req_valid = 1'b1; req_code = c; req_row = r; req_tall = t;
      @(negedge clk);
      req_valid = 1'b0;
      got = pat_bits;
   endtask

   task automatic t_reset();
      logic [4:0] g;
      @(negedge clk);
      chk("R10 valid after reset", {7'b0, pat_valid}, 8'h00);
      chk("R10 bits after reset", {3'b0, pat_bits}, 8'h00);
      fetch(8'h03, 4'd5, 1'b0, g);
      chk("R10 ram cleared", {3'b0, g}, 8'h00);
   endtask

   task automatic t_table();
      logic [4:0] g;
      fetch(8'h10, 4'd0, 1'b0, g);
      chk("R1 code 10 row 0", {3'b0, g}, {3'b0, table_pat(8'h10, 4'd0)});
      fetch(8'h41, 4'd7, 1'b0, g);
      chk("R1 code 41 row 7", {3'b0, g}, {3'b0, table_pat(8'h41, 4'd7)});
      fetch(8'h7F, 4'd9, 1'b1, g);
      chk("R1 code 7F row 9 tall", {3'b0, g}, {3'b0, table_pat(8'h7F, 4'd9)});
      fetch(8'h2A, 4'd3, 1'b0, g);
      chk("R2 upper bits dropped", {3'b0, g}, {3'b0, 5'h0A ^ 5'h03});
   endtask

   task automatic t_unprog();
      logic [4:0] g;
      fetch(8'h80, 4'd0, 1'b0, g);
      chk("R7 code 80 all lit", {3'b0, g}, 8'h1F);
      fetch(8'hFF, 4'd9, 1'b1, g);
      chk("R7 code FF tall row 9 lit", {3'b0, g}, 8'h1F);
   endtask

   task automatic t_blank();
      logic [4:0] g;
      fetch(8'hC0, 4'd8, 1'b0, g);
      chk("R3 short row 8 blank", {3'b0, g}, 8'h00);
      fetch(8'h31, 4'd15, 1'b0, g);
      chk("R3 short row 15 blank", {3'b0, g}, 8'h00);
      fetch(8'h31, 4'd8, 1'b1, g);
      chk("R4 tall row 8 lit", {3'b0, g}, {3'b0, table_pat(8'h31, 4'd8)});
      fetch(8'hC0, 4'd10, 1'b1, g);
      chk("R4 tall row 10 blank", {3'b0, g}, 8'h00);
      fetch(8'h31, 4'd12, 1'b1, g);
      chk("R4 tall row 12 blank", {3'b0, g}, 8'h00);
   endtask

   task automatic t_ram_short();
      logic [4:0] g;
      write_ram(6'd2, 8'hE5);
      write_ram(6'd29, 8'h0C);
      fetch(8'h00, 4'd2, 1'b0, g);
      chk("R5 code 00 row 2", {3'b0, g}, 8'h05);
      fetch(8'h08, 4'd2, 1'b0, g);
      chk("R5 code 08 aliases 00", {3'b0, g}, 8'h05);
      fetch(8'h03, 4'd5, 1'b0, g);
      chk("R5 code 03 row 5", {3'b0, g}, 8'h0C);
      write_ram(6'd0, 8'h11);
      fetch(8'h00, 4'd8, 1'b0, g);
      chk("R3 ram row 8 blank", {3'b0, g}, 8'h00);
   endtask

   task automatic t_ram_tall();
      logic [4:0] g;
      write_ram(6'd9, 8'h16);
      write_ram(6'd57, 8'h09);
      fetch(8'h00, 4'd9, 1'b1, g);
      chk("R6 code 00 row 9 tall", {3'b0, g}, 8'h16);
      fetch(8'h04, 4'd9, 1'b1, g);
      chk("R6 code 04 aliases 00", {3'b0, g}, 8'h16);
      fetch(8'h03, 4'd9, 1'b1, g);
      chk("R6 code 03 row 9 tall", {3'b0, g}, 8'h09);
   endtask

   task automatic t_collision();
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'd21; wr_data = 8'hF3;
      req_valid = 1'b1; req_code = 8'h02; req_row = 4'd5; req_tall = 1'b0;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      chk("R9 write wins collision", {3'b0, pat_bits}, 8'h13);
   endtask

   task automatic t_latency();
      @(negedge clk);
      req_valid = 1'b1; req_code = 8'h55; req_row = 4'd1; req_tall = 1'b0;
      @(negedge clk);
      chk("R8 valid after request", {7'b0, pat_valid}, 8'h01);
      chk("R8 bits of request", {3'b0, pat_bits}, {3'b0, table_pat(8'h55, 4'd1)});
      req_valid = 1'b0;
      @(negedge clk);
      chk("R8 valid drops", {7'b0, pat_valid}, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_code = '0; req_row = '0; req_tall = 1'b0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_table();
      t_unprog();
      t_blank();
      t_ram_short();
      t_ram_tall();
      t_collision();
      t_latency();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule